// File: doc/BRIEF.md
# System Address Range Target Decoder

This block maps a physical address to the socket, memory controller and channel that own it. Software first loads a table of range entries through a register-write port. Each entry has a range word and an interleave-list word. Software also drives a static route word and the low and high memory top values. A request is a one-cycle `start` with an address. The block first rejects addresses in the I/O hole or above the top of memory. It then walks the range entries one per clock and stops at the first enabled entry whose range contains the address.

For the matching entry, a group of address bits picks one 4-bit target from the interleave word. A target with its top bit clear belongs to another socket: the block reports it as remote and does no more decoding. A local target gives a logical channel, either directly or through a modulo-3 or modulo-2 hash of the address. The logical channel then selects a controller field and a channel field in the route word. Every request ends in a single-cycle result pulse with an error code.

Top module: `addr_target_decoder`

## Requirements
- R1: After reset, `busy` and `res_valid` are low, and every table word reads as zero, so every entry is disabled.
- R2: An address at or above `high_top`, or below 2^32 and at or above `low_top`, ends with error code 1 (range). `res_valid` rises at the same clock edge that samples `start`.
- R3: Range words decode as: bit 0 is the enable and bits 26:7 are the limit field. The inclusive upper bound is the field times 2^26 plus 2^26-1. Entries are tried from 0 upward, and entry k covers from the previous bound plus one (0 for entry 0) up to its own bound. A disabled entry still moves the lower bound. The first hit wins and `res_entry` gives its index. A hit at entry k makes `res_valid` rise k+1 edges after the edge that sampled `start`.
- R4: If no entry matches, the result is error code 2 (no match), N_ENT edges after the start edge.
- R5: Range bits 2:1 select the 3-bit interleave index from address bits 8:6 (0), 10:8 (1), 14:12 (2) or 32:30 (3). The target is interleave-word bits [4*idx+3:4*idx].
- R6: A target whose bit 3 is clear is remote. The result has error 0, `res_remote` high, `res_tgt` equal to target bits 2:0, and zero controller and channel.
- R7: For a local target with range bit 27 clear, the logical channel L is the target id. `res_mc` is route bits [3L+2:3L]. `res_chan` is route bits [2L+19:2L+18], and route bits above 31 read as zero.
- R8: With range bit 27 set, bits 31:30 pick a shift of 6, 8 or 12 (codes 0, 1, 2), and Q is the address shifted right by that amount. Bits 6:5 pick the hash: 0 gives Q mod 3, 1 gives Q mod 2, and 3 gives (Q mod 2) times 2. L is then the hash value shifted left by one, ORed with target bit 0.
- R9: For a local target with range bit 27 set, a shift code of 3 or a hash mode of 2 gives error code 3 (illegal mode).
- R10: A `start` seen while `busy` is high has no effect on the request in progress.
- R11: `busy` is high from the start edge until the result edge of a request that scans. `res_valid` is low while `busy` is high and lasts one cycle unless a new request ends at once.
- R12: When the error code is not 0, `res_remote`, `res_tgt`, `res_mc` and `res_chan` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_ilv | input | 1 | 1 writes the interleave word, 0 writes the range word |
| cfg_idx | input | ENT_W | Entry index to write; indices of N_ENT and above are ignored |
| cfg_wdata | input | 32 | Write data |
| route_word | input | 32 | Logical channel to controller and channel route |
| low_top | input | 32 | Top of low memory |
| high_top | input | 46 | Top of high memory |
| start | input | 1 | Request strobe |
| addr | input | 46 | Physical address of the request |
| busy | output | 1 | Scan in progress |
| res_valid | output | 1 | Result pulse |
| res_err | output | 2 | 0 none, 1 range, 2 no match, 3 illegal mode |
| res_remote | output | 1 | Target lives on another socket |
| res_tgt | output | 3 | Target id |
| res_mc | output | 3 | Memory controller index |
| res_chan | output | 2 | Channel index |
| res_entry | output | ENT_W | Index of the matching entry |

## Verification
A wrong scan index or lower bound changes when `res_valid` rises, or which entry and target it reports. The bench predicts the exact result edge of every request, so such a fault shows on the first request whose address lands in a later entry. A fault in the hash or route selection shows as a wrong controller or channel at that request's result pulse. The bench reloads randomized tables many times and picks addresses at entry boundaries, which brings these cases out within a few hundred requests.

// File: rtl/ard_pkg.sv
package ard_pkg;
  localparam int unsigned LIM_LSB = 26;
  localparam int unsigned LIM_W   = 20;
  localparam int unsigned LIM_POS = 7;
  localparam int unsigned ADDR_W  = LIM_LSB + LIM_W;
  localparam int unsigned WORD_W  = 32;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_RANGE   = 2'd1,
    ERR_NOMATCH = 2'd2,
    ERR_MODE    = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    FIN_NONE = 2'd0,
    FIN_OOR  = 2'd1,
    FIN_MISS = 2'd2,
    FIN_HIT  = 2'd3
  } fin_e;

  typedef struct packed {
    logic       remote;
    logic [2:0] tgt;
    logic [2:0] mc;
    logic [1:0] ch;
    logic       bad_mode;
  } route_res_t;

  // Residue modulo 3, most significant bit first.
  function automatic logic [1:0] mod3_of(input logic [ADDR_W-1:0] v);
    logic [1:0] acc;
    logic [2:0] t;
    acc = 2'd0;
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      t   = {acc, 1'b0} + {2'b00, v[i]};
      acc = (t >= 3'd3) ? 2'(t - 3'd3) : t[1:0];
    end
    return acc;
  endfunction
endpackage

// File: rtl/ard_table.sv
module ard_table
  import ard_pkg::*;
#(
  parameter  int N_ENT = 24,
  localparam int ENT_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ilv,
  input  logic [ENT_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ENT_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_range,
  output logic [WORD_W-1:0] rd_ilv
);
  logic [WORD_W-1:0] rng_arr [N_ENT];
  logic [WORD_W-1:0] ilv_arr [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic              sel;
    logic [WORD_W-1:0] rng_q;
    logic [WORD_W-1:0] ilv_q;
    assign sel = wr_en && (wr_idx == ENT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rng_q <= '0;
        ilv_q <= '0;
      end else begin
        if (sel && !wr_ilv) rng_q <= wr_data;
        if (sel && wr_ilv)  ilv_q <= wr_data;
      end
    end
    assign rng_arr[g] = rng_q;
    assign ilv_arr[g] = ilv_q;
  end

  always_comb begin
    rd_range = '0;
    rd_ilv   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (rd_idx == ENT_W'(i)) begin
        rd_range = rng_arr[i];
        rd_ilv   = ilv_arr[i];
      end
    end
  end
endmodule

// File: rtl/ard_scan.sv
module ard_scan
  import ard_pkg::*;
#(
  parameter  int N_ENT = 24,
  localparam int ENT_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [31:0]       low_top,
  input  logic [ADDR_W-1:0] high_top,
  input  logic [WORD_W-1:0] rng_word,
  output logic [ENT_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr_q,
  output logic              busy,
  output fin_e              fin
);
  logic              busy_q, busy_d;
  logic [ENT_W-1:0]  idx_q, idx_d;
  logic [ADDR_W:0]   lo_q, lo_d;
  logic              ld;
  logic              oor, hit, last;
  logic [ADDR_W-1:0] lim;
  logic              unused_rng;

  assign unused_rng = ^{rng_word[WORD_W-1:LIM_POS+LIM_W], rng_word[LIM_POS-1:1]};

  assign lim  = {rng_word[LIM_POS+LIM_W-1:LIM_POS], {LIM_LSB{1'b1}}};
  assign oor  = (addr_in >= high_top) ||
                ((addr_in[ADDR_W-1:32] == '0) && (addr_in[31:0] >= low_top));
  assign hit  = busy_q && rng_word[0] && ({1'b0, addr_q} >= lo_q) && (addr_q <= lim);
  assign last = (idx_q == ENT_W'(N_ENT - 1));

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    lo_d   = lo_q;
    ld     = 1'b0;
    fin    = FIN_NONE;
    if (!busy_q) begin
      if (start) begin
        if (oor) begin
          fin = FIN_OOR;
        end else begin
          busy_d = 1'b1;
          idx_d  = '0;
          lo_d   = '0;
          ld     = 1'b1;
        end
      end
    end else if (hit) begin
      fin    = FIN_HIT;
      busy_d = 1'b0;
    end else if (last) begin
      fin    = FIN_MISS;
      busy_d = 1'b0;
    end else begin
      idx_d = idx_q + ENT_W'(1);
      lo_d  = {1'b0, lim} + (ADDR_W + 1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      lo_q   <= '0;
      addr_q <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      lo_q   <= lo_d;
      if (ld) addr_q <= addr_in;
    end
  end

  assign idx  = idx_q;
  assign busy = busy_q;

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(idx_q) < N_ENT)); // R3
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fin == FIN_NONE) |=> (busy_q && idx_q == $past(idx_q) + ENT_W'(1))); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(addr_q)); // R10
endmodule

// File: rtl/ard_resolve.sv
module ard_resolve
  import ard_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] rng_word,
  input  logic [WORD_W-1:0] ilv_word,
  input  logic [31:0]       route,
  output route_res_t        res
);
  logic [2:0]        nidx;
  logic [3:0]        nib;
  logic [ADDR_W-1:0] sh;
  logic [1:0]        m3;
  logic [1:0]        pick;
  logic              bad_hash;
  logic [2:0]        lchan;
  logic [33:0]       route_x;
  logic              unused_bits;

  assign unused_bits = ^{rng_word[29:28], rng_word[26:7], rng_word[4:3], rng_word[0]};

  always_comb begin
    case (rng_word[2:1])
      2'd0:    nidx = addr[8:6];
      2'd1:    nidx = addr[10:8];
      2'd2:    nidx = addr[14:12];
      default: nidx = addr[32:30];
    endcase
  end

  assign nib = ilv_word[4*int'(nidx) +: 4];

  always_comb begin
    case (rng_word[31:30])
      2'd0:    sh = addr >> 6;
      2'd1:    sh = addr >> 8;
      2'd2:    sh = addr >> 12;
      default: sh = '0;
    endcase
  end

  assign m3 = mod3_of(sh);

  always_comb begin
    bad_hash = 1'b0;
    case (rng_word[6:5])
      2'd0:    pick = m3;
      2'd1:    pick = {1'b0, sh[0]};
      2'd3:    pick = {sh[0], 1'b0};
      default: begin
        pick     = 2'd0;
        bad_hash = 1'b1;
      end
    endcase
  end

  assign lchan   = rng_word[27] ? {pick, nib[0]} : nib[2:0];
  assign route_x = {2'b00, route};

  always_comb begin
    res.remote   = ~nib[3];
    res.tgt      = nib[2:0];
    res.mc       = route_x[3*int'(lchan) +: 3];
    res.ch       = route_x[2*int'(lchan) + 18 +: 2];
    res.bad_mode = rng_word[27] && ((rng_word[31:30] == 2'd3) || bad_hash);
  end
endmodule

// File: rtl/addr_target_decoder.sv
module addr_target_decoder
  import ard_pkg::*;
#(
  parameter  int N_ENT = 24,
  localparam int ENT_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_ilv,
  input  logic [ENT_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic [31:0]       route_word,
  input  logic [31:0]       low_top,
  input  logic [45:0]       high_top,
  input  logic              start,
  input  logic [45:0]       addr,
  output logic              busy,
  output logic              res_valid,
  output logic [1:0]        res_err,
  output logic              res_remote,
  output logic [2:0]        res_tgt,
  output logic [2:0]        res_mc,
  output logic [1:0]        res_chan,
  output logic [ENT_W-1:0]  res_entry
);
  logic [ENT_W-1:0]  scan_idx;
  logic [ADDR_W-1:0] scan_addr;
  logic [WORD_W-1:0] rng_word, ilv_word;
  fin_e              fin;
  route_res_t        rr;

  ard_table #(.N_ENT(N_ENT)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_ilv(cfg_ilv), .wr_idx(cfg_idx),
    .wr_data(cfg_wdata), .rd_idx(scan_idx), .rd_range(rng_word), .rd_ilv(ilv_word)
  );

  ard_scan #(.N_ENT(N_ENT)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr), .low_top(low_top),
    .high_top(high_top), .rng_word(rng_word), .idx(scan_idx), .addr_q(scan_addr),
    .busy(busy), .fin(fin)
  );

  ard_resolve u_resolve (
    .addr(scan_addr), .rng_word(rng_word), .ilv_word(ilv_word), .route(route_word), .res(rr)
  );

  logic             v_d, v_q;
  err_e             err_d, err_q;
  logic             rem_d, rem_q;
  logic [2:0]       tgt_d, tgt_q, mc_d, mc_q;
  logic [1:0]       ch_d, ch_q;
  logic [ENT_W-1:0] ent_d, ent_q;

  always_comb begin
    v_d   = (fin != FIN_NONE);
    err_d = ERR_NONE;
    rem_d = 1'b0;
    tgt_d = '0;
    mc_d  = '0;
    ch_d  = '0;
    ent_d = '0;
    case (fin)
      FIN_OOR:  err_d = ERR_RANGE;
      FIN_MISS: err_d = ERR_NOMATCH;
      FIN_HIT: begin
        ent_d = scan_idx;
        if (rr.remote) begin
          rem_d = 1'b1;
          tgt_d = rr.tgt;
        end else if (rr.bad_mode) begin
          err_d = ERR_MODE;
        end else begin
          tgt_d = rr.tgt;
          mc_d  = rr.mc;
          ch_d  = rr.ch;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      err_q <= ERR_NONE;
      rem_q <= 1'b0;
      tgt_q <= '0;
      mc_q  <= '0;
      ch_q  <= '0;
      ent_q <= '0;
    end else begin
      v_q <= v_d;
      if (v_d) begin
        err_q <= err_d;
        rem_q <= rem_d;
        tgt_q <= tgt_d;
        mc_q  <= mc_d;
        ch_q  <= ch_d;
        ent_q <= ent_d;
      end
    end
  end

  assign res_valid  = v_q;
  assign res_err    = err_q;
  assign res_remote = rem_q;
  assign res_tgt    = tgt_q;
  assign res_mc     = mc_q;
  assign res_chan   = ch_q;
  assign res_entry  = ent_q;

  AST_TOP_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && addr >= high_top) |=> (res_valid && res_err == 2'd1)); // R2
  AST_REMOTE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_remote) |-> (res_err == 2'd0 && res_mc == 3'd0 && res_chan == 2'd0)); // R6
  AST_ERR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err != 2'd0) |-> (!res_remote && res_tgt == 3'd0 && res_mc == 3'd0 && res_chan == 2'd0)); // R12
  AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !res_valid); // R11
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || res_valid)); // R11
endmodule

// File: tb/test_addr_target_decoder.sv
module test_addr_target_decoder;
  localparam int N  = 24;
  localparam int EW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, cfg_we, cfg_ilv, start;
  logic [EW-1:0] cfg_idx;
  logic [31:0]   cfg_wdata, route_word, low_top;
  logic [45:0]   high_top, addr;
  logic          busy, res_valid, res_remote;
  logic [1:0]    res_err, res_chan;
  logic [2:0]    res_tgt, res_mc;
  logic [EW-1:0] res_entry;

  addr_target_decoder i_addr_target_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ilv(cfg_ilv), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .route_word(route_word), .low_top(low_top), .high_top(high_top),
    .start(start), .addr(addr), .busy(busy), .res_valid(res_valid), .res_err(res_err),
    .res_remote(res_remote), .res_tgt(res_tgt), .res_mc(res_mc), .res_chan(res_chan),
    .res_entry(res_entry)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  longint unsigned m_rng [N];
  longint unsigned m_ilv [N];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit ilv, input int idx, input longint unsigned data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ilv = ilv; cfg_idx = EW'(idx); cfg_wdata = data[31:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < N) begin
      if (ilv) m_ilv[idx] = data; else m_rng[idx] = data;
    end
  endtask

  // Behavioural model of one request.
  task automatic model(input longint unsigned a, output int e, output int rem, output int tg,
                       output int mc, output int ch, output int en, output int lat,
                       output string tag);
    longint unsigned lo, lim, w, q, rt;
    int hitk, sel, pos, ix, nib, t, l, sc, hm, s;
    e = 0; rem = 0; tg = 0; mc = 0; ch = 0; en = 0; lat = 0; tag = "R7";
    rt = longint'(route_word);
    if (a >= longint'(high_top) || (a >= longint'(low_top) && a < 64'h1_0000_0000)) begin
      e = 1; tag = "R2"; return;
    end
    lo = 0; hitk = -1;
    for (int i = 0; i < N; i++) begin
      lim = (((m_rng[i] >> 7) & 64'hFFFFF) << 26) | 64'h3FFFFFF;
      if ((m_rng[i] & 1) != 0 && a >= lo && a <= lim) begin hitk = i; break; end
      lo = lim + 1;
    end
    if (hitk < 0) begin e = 2; lat = N; tag = "R4"; return; end
    en = hitk; lat = hitk + 1;
    w = m_rng[hitk];
    sel = int'((w >> 1) & 3);
    pos = (sel == 0) ? 6 : (sel == 1) ? 8 : (sel == 2) ? 12 : 30;
    ix = int'((a >> pos) & 7);
    nib = int'((m_ilv[hitk] >> (4 * ix)) & 15);
    t = nib & 7;
    if ((nib & 8) == 0) begin rem = 1; tg = t; tag = "R6"; return; end
    if (((w >> 27) & 1) == 0) begin
      l = t;
    end else begin
      sc = int'((w >> 30) & 3);
      hm = int'((w >> 5) & 3);
      if (sc == 3 || hm == 2) begin e = 3; tag = "R9"; return; end
      s = (sc == 0) ? 6 : (sc == 1) ? 8 : 12;
      q = a >> s;
      if (hm == 0) l = int'(q % 3);
      else if (hm == 1) l = int'(q % 2);
      else l = int'((q % 2) << 1);
      l = (l << 1) | (t & 1);
      tag = "R8";
    end
    tg = t;
    mc = int'((rt >> (3 * l)) & 7);
    ch = int'((rt >> (2 * l + 18)) & 3);
  endtask

  // One request; compares the outputs on every clock until the result.
  task automatic run(input longint unsigned a, input int poke_at, input longint unsigned poke_addr);
    int e, rem, tg, mc, ch, en, lat;
    string tag, ftag;
    model(a, e, rem, tg, mc, ch, en, lat, tag);
    @(negedge clk);
    start = 1'b1; addr = 46'(a);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= lat; c++) begin
      if (c > 0) @(negedge clk);
      if (c == poke_at) begin start = 1'b1; addr = 46'(poke_addr); end
      else start = 1'b0;
      if (c < lat) begin
        chk(poke_at >= 0 ? "R10 no early result" : "R11 quiet while scanning", res_valid, 0);
        chk("R11 busy during scan", busy, 1);
      end else begin
        start = 1'b0;
        ftag = (e != 0) ? "R12" : tag;
        chk({tag, " valid"}, res_valid, 1);
        chk({tag, " err"}, res_err, e);
        chk({tag, " busy at result"}, busy, 0);
        chk({ftag, " remote"}, res_remote, rem);
        chk({ftag, " R5 target"}, res_tgt, tg);
        chk({ftag, " mc"}, res_mc, mc);
        chk({ftag, " chan"}, res_chan, ch);
        if (e != 1 && e != 2) chk("R3 entry", res_entry, en);
      end
    end
    @(negedge clk);
    chk("R11 pulse ends", res_valid, 0);
    chk("R11 idle after result", busy, 0);
  endtask

  task automatic load_random_table();
    longint unsigned acc, w;
    acc = 0;
    for (int i = 0; i < N; i++) begin
      acc = acc + longint'($urandom_range(0, 5));
      w = longint'($urandom) & ~(64'hFFFFF << 7);
      w = w | ((acc & 64'hFFFFF) << 7);
      if ($urandom_range(0, 3) == 0) w = w & ~64'h1; else w = w | 64'h1;
      wr(1'b0, i, w);
      wr(1'b1, i, longint'($urandom));
      acc = acc + 1;
    end
    route_word = $urandom;
  endtask

  function automatic longint unsigned pick_addr();
    longint unsigned lim;
    int k;
    if ($urandom_range(0, 3) == 0) begin
      k = $urandom_range(0, N - 1);
      lim = (((m_rng[k] >> 7) & 64'hFFFFF) << 26) | 64'h3FFFFFF;
      return lim + longint'($urandom_range(0, 1));
    end
    return {30'd0, 1'($urandom_range(0, 1)), 1'b0, $urandom};
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ilv = 1'b0; cfg_idx = '0; cfg_wdata = '0; start = 1'b0;
    addr = '0; route_word = 32'h0; low_top = 32'hC000_0000; high_top = 46'h1_F000_0000;
    for (int i = 0; i < N; i++) begin m_rng[i] = 0; m_ilv[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 valid after reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid idle", res_valid, 0);

    // Empty table: every entry disabled, so a legal address misses (R1, R4).
    run(64'h1000, -1, 0);
    // Start during the scan with an out-of-range address is ignored (R10).
    run(64'h2_0000, 5, 64'hC000_0000);
    // Range rule corners (R2).
    run(64'hC000_0000, -1, 0);
    run(64'hFFFF_FFFF, -1, 0);
    run(64'h1_F000_0000, -1, 0);
    run(64'hBFFF_FFFF, -1, 0);

    for (int t = 0; t < 12; t++) begin
      load_random_table();
      for (int r = 0; r < 35; r++) run(pick_addr(), -1, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule